// File: doc/BRIEF.md
# Grouped GPIO Interrupt Front End

This block turns the pins of a four-port GPIO unit into a single CPU interrupt. No pin has interrupt logic of its own. Instead, eight interrupt groups exist, and each group watches exactly one pin. A group's 4-bit source selector names a port and a byte lane within that port. Group g then observes bit g of that byte lane, so a pin whose index in its port is n can only be served by group n mod 8.

Each group has a 3-bit trigger field that selects one of these behaviours:
- off
- level high
- level low
- forced pending
- rising edge
- falling edge
- any edge

The group's pending state is combined with a per-group mask. The masked result drives the interrupt line and can be read back over a plain 32-bit register port. Edge events are sticky and are cleared by writing ones to the acknowledge register. Level conditions follow the pin directly.

Pins are passed through a two-flop synchronizer before detection. Register writes take effect on the clock edge where the write strobe is sampled. A read strobe returns data one cycle later, flagged by a valid pulse. The register port has no back-pressure and accepts one access per cycle. It is a control interface, so it carries no valid/ready handshake.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset, the trigger, selector, mask and pending state are all zero and `irq_out` is low. Reading any register returns 0.
- R2: The register offsets are as follows:
  - offset 120: trigger register, 24 bits; bits 31:24 read as 0.
  - offset 124: selector register, 32 bits.
  - offset 128: mask register, bits 7:0.
  - offset 132: acknowledge register; it reads as 0.
  - offset 140: masked status.

  A read strobe yields `reg_rvalid` and the data on the next cycle, and 0 is returned when no read is performed.
- R3: Group g's selector occupies bits [4g+3:4g] of the selector register. A selector value s picks bit 8*(s mod 4)+g of port s/4, where ports A, B, C and D are 0, 1, 2 and 3. Selectors that point at the missing bits 16..31 of port C observe a constant 0.
- R4: Group g's trigger code occupies bits [3g+2:3g] of the trigger register. With code 1 (level high) or code 2 (level low), pending equals the sampled pin level, or its inverse for code 2, and acknowledge writes have no effect.
- R5: With code 3, the group is pending on every cycle.
- R6: Codes 5 (rising), 6 (falling) and 7 (either edge) set pending on the matching transition of the sampled pin. The pending state then holds until it is acknowledged.
- R7: Writing a 1 to bit g of the acknowledge register clears an edge-mode pending state. If an edge is detected in the same cycle as the acknowledge, the edge wins.
- R8: Codes 0 and 4 clear pending and ignore all pin activity.
- R9: Masked status holds the pending bits ANDed with the mask in bits 7:0, and bits 31:8 read as 0.
- R10: `irq_out` is high exactly when any masked status bit is set.
- R11: A pin change reaches pending on the third rising clock edge after the change: two synchronizer stages, then the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| pa_in | input | 32 | Port A pin levels |
| pb_in | input | 32 | Port B pin levels |
| pc_in | input | 16 | Port C pin levels |
| pd_in | input | 32 | Port D pin levels (input-only port) |
| irq_out | output | 1 | CPU interrupt request |

## Verification
The in-RTL assertions check the following on every cycle:
- forced-pending mode;
- the level-follow rule;
- the stickiness of edge-mode pending;
- acknowledge clearing;
- off-mode clearing;
- the zero-mask gate on the interrupt;
- the read latency and the zeroed upper read bits.

Only the bench's scenarios can show the remaining behaviours:
- pin routing through the selector, including the missing port C lanes;
- the exact three-edge latency;
- edge-versus-acknowledge collisions on the same edge;
- the end-to-end agreement of status readback with a behavioural model under random register and pin traffic.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NGRP     = 8;
  localparam int TRG_BITS = 3;
  localparam int SEL_BITS = 4;
  localparam int LANE_W   = 8;
  localparam int LANES    = 4;

  typedef enum logic [TRG_BITS-1:0] {
    TRG_OFF  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_LOW  = 3'd2,
    TRG_SET  = 3'd3,
    TRG_RSV  = 3'd4,
    TRG_RISE = 3'd5,
    TRG_FALL = 3'd6,
    TRG_ANY  = 3'd7
  } trig_t;

  localparam logic [7:0] OFS_TRIG = 8'd120;
  localparam logic [7:0] OFS_SEL  = 8'd124;
  localparam logic [7:0] OFS_MASK = 8'd128;
  localparam logic [7:0] OFS_ACK  = 8'd132;
  localparam logic [7:0] OFS_STAT = 8'd140;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
  import gpio_irq_pkg::*;
#(
  parameter int GIDX  = 0,
  parameter int SRC_W = 128,
  parameter int SELW  = 4,
  parameter int LANE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [SELW-1:0]  sel,
  input  trig_t            mode,
  input  logic             ack,
  output logic             pend
);
  localparam int IW = $clog2(SRC_W);

  logic [IW-1:0] idx;
  logic          cur;
  logic          prev;
  logic          edge_evt;
  logic          edge_mode;
  logic          pend_nxt;

  assign idx = IW'(sel) * IW'(LANE) + IW'(GIDX);
  assign cur = src[idx];

  assign edge_mode = (mode == TRG_RISE) || (mode == TRG_FALL) || (mode == TRG_ANY);

  always_comb begin
    case (mode)
      TRG_RISE: edge_evt = cur & ~prev;
      TRG_FALL: edge_evt = ~cur & prev;
      TRG_ANY:  edge_evt = cur ^ prev;
      default:  edge_evt = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      TRG_HIGH: pend_nxt = cur;
      TRG_LOW:  pend_nxt = ~cur;
      TRG_SET:  pend_nxt = 1'b1;
      TRG_RISE, TRG_FALL, TRG_ANY: pend_nxt = edge_evt | (pend & ~ack);
      default:  pend_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= cur;
      pend <= pend_nxt;
    end
  end

  p_set_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRG_SET) |=> pend);
  p_level_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRG_HIGH) |=> (pend == $past(cur)));
  p_level_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRG_LOW) |=> (pend == !$past(cur)));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend && !ack) |=> pend);
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !edge_evt) |=> !pend);
  p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TRG_OFF) || (mode == TRG_RSV)) |=> !pend);
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
  import gpio_irq_pkg::*;
#(
  parameter int PA_W = 32,
  parameter int PB_W = 32,
  parameter int PC_W = 16,
  parameter int PD_W = 32,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            reg_rvalid,
  input  logic [PA_W-1:0] pa_in,
  input  logic [PB_W-1:0] pb_in,
  input  logic [PC_W-1:0] pc_in,
  input  logic [PD_W-1:0] pd_in,
  output logic            irq_out
);
  localparam int SLOT   = LANES * LANE_W;
  localparam int NPORT  = 4;
  localparam int SRC_W  = NPORT * SLOT;
  localparam int IN_W   = PA_W + PB_W + PC_W + PD_W;
  localparam int OFF_B  = PA_W;
  localparam int OFF_C  = PA_W + PB_W;
  localparam int OFF_D  = PA_W + PB_W + PC_W;
  localparam int TRG_W  = NGRP * TRG_BITS;
  localparam int SELR_W = NGRP * SEL_BITS;

  logic [IN_W-1:0]   sync_q;
  logic [SRC_W-1:0]  src_flat;
  logic [TRG_W-1:0]  trig_q;
  logic [SELR_W-1:0] sel_q;
  logic [NGRP-1:0]   mask_q;
  logic [NGRP-1:0]   pend;
  logic [NGRP-1:0]   ack_vec;
  logic [NGRP-1:0]   masked;
  logic [DW-1:0]     rd_mux;

  gpio_irq_sync #(.W(IN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pd_in, pc_in, pb_in, pa_in}),
    .q     (sync_q)
  );

  // Each port occupies one SLOT-wide window; missing pins read as zero.
  assign src_flat = {SLOT'(sync_q[OFF_D +: PD_W]),
                     SLOT'(sync_q[OFF_C +: PC_W]),
                     SLOT'(sync_q[OFF_B +: PB_W]),
                     SLOT'(sync_q[0 +: PA_W])};

  assign ack_vec = (reg_wr && reg_addr == AW'(OFS_ACK)) ? reg_wdata[NGRP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      sel_q  <= '0;
      mask_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        AW'(OFS_TRIG): trig_q <= reg_wdata[TRG_W-1:0];
        AW'(OFS_SEL):  sel_q  <= reg_wdata[SELR_W-1:0];
        AW'(OFS_MASK): mask_q <= reg_wdata[NGRP-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gpio_irq_group #(
      .GIDX  (g),
      .SRC_W (SRC_W),
      .SELW  (SEL_BITS),
      .LANE  (LANE_W)
    ) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_flat),
      .sel   (sel_q[g*SEL_BITS +: SEL_BITS]),
      .mode  (trig_t'(trig_q[g*TRG_BITS +: TRG_BITS])),
      .ack   (ack_vec[g]),
      .pend  (pend[g])
    );
  end

  assign masked  = pend & mask_q;
  assign irq_out = |masked;

  always_comb begin
    case (reg_addr)
      AW'(OFS_TRIG): rd_mux = DW'(trig_q);
      AW'(OFS_SEL):  rd_mux = DW'(sel_q);
      AW'(OFS_MASK): rd_mux = DW'(mask_q);
      AW'(OFS_STAT): rd_mux = DW'(masked);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_rdata  <= reg_rd ? rd_mux : '0;
    end
  end

  p_mask_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out);
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  p_trig_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(OFS_TRIG)) |=> (reg_rdata[DW-1:TRG_W] == '0));
  p_stat_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(OFS_STAT)) |=> (reg_rdata[DW-1:NGRP] == '0));
endmodule

// File: tb/gpio_irq_front_bench.sv
module gpio_irq_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [31:0] pa_in = '0;
  logic [31:0] pb_in = '0;
  logic [15:0] pc_in = '0;
  logic [31:0] pd_in = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  gpio_irq_front u_gpio_irq_front (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .reg_rvalid, .pa_in, .pb_in, .pc_in, .pd_in, .irq_out
  );

  localparam logic [7:0] A_TRIG = 8'd120, A_SEL = 8'd124, A_MASK = 8'd128,
                         A_ACK = 8'd132, A_STAT = 8'd140;

  // behavioural reference model
  logic [127:0] m_s1, m_s2;
  logic [7:0]   m_prev, m_pend, m_mask;
  logic [23:0]  m_trig;
  logic [31:0]  m_sel, m_rdata;
  logic         m_rv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '0;
      m_trig = '0; m_sel = '0; m_rdata = '0; m_rv = 1'b0;
    end else begin
      m_rv = reg_rd;
      m_rdata = '0;
      if (reg_rd) begin
        if (reg_addr == A_TRIG) m_rdata = {8'h0, m_trig};
        else if (reg_addr == A_SEL) m_rdata = m_sel;
        else if (reg_addr == A_MASK) m_rdata = {24'h0, m_mask};
        else if (reg_addr == A_STAT) m_rdata = {24'h0, m_pend & m_mask};
      end
      for (int g = 0; g < 8; g++) begin
        int md;
        int ix;
        bit c, ak, ev;
        md = int'(m_trig[3*g +: 3]);
        ix = int'(m_sel[4*g +: 4]) * 8 + g;
        c  = m_s2[ix];
        ak = reg_wr && (reg_addr == A_ACK) && reg_wdata[g];
        ev = (md == 5 && c && !m_prev[g]) || (md == 6 && !c && m_prev[g]) ||
             (md == 7 && c != m_prev[g]);
        if (md == 1) m_pend[g] = c;
        else if (md == 2) m_pend[g] = !c;
        else if (md == 3) m_pend[g] = 1'b1;
        else if (md >= 5) m_pend[g] = ev || (m_pend[g] && !ak);
        else m_pend[g] = 1'b0;
        m_prev[g] = c;
      end
      if (reg_wr) begin
        if (reg_addr == A_TRIG) m_trig = reg_wdata[23:0];
        else if (reg_addr == A_SEL) m_sel = reg_wdata;
        else if (reg_addr == A_MASK) m_mask = reg_wdata[7:0];
      end
      m_s2 = m_s1;
      m_s1 = {pd_in, 16'h0, pc_in, pb_in, pa_in};
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R10", 32'(irq_out), 32'(|(m_pend & m_mask)));
      check("R2", 32'(reg_rvalid), 32'(m_rv));
      check(cur_tag, reg_rdata, m_rdata);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    reg_rd = 1'b1; reg_addr = a;
    cyc(1);
    reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++;
      $display("FAIL R11 watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    cur_tag = "R1";
    check("R1", 32'(irq_out), 0);
    rd_chk(A_TRIG, 0, "R1"); rd_chk(A_SEL, 0, "R1");
    rd_chk(A_MASK, 0, "R1"); rd_chk(A_STAT, 0, "R1");

    // R2 register map
    cur_tag = "R2";
    wr(A_TRIG, 32'hFFFF_FFFF); rd_chk(A_TRIG, 32'h00FF_FFFF, "R2");
    wr(A_SEL, 32'hA5A5_1234);  rd_chk(A_SEL, 32'hA5A5_1234, "R2");
    wr(A_MASK, 32'hFFFF_FF3C); rd_chk(A_MASK, 32'h0000_003C, "R2");
    rd_chk(A_ACK, 0, "R2");
    wr(A_TRIG, 0); wr(A_SEL, 0); wr(A_MASK, 0);
    cyc(2);

    // R4 / R11 level high on group 0, port A bit 0
    cur_tag = "R4";
    wr(A_TRIG, 32'd1); wr(A_MASK, 32'h1);
    pa_in[0] = 1'b1;
    cyc(2); check("R11", 32'(irq_out), 0);
    cyc(1); check("R11", 32'(irq_out), 1);
    wr(A_ACK, 32'hFF); cyc(1); check("R4", 32'(irq_out), 1);
    pa_in[0] = 1'b0; cyc(3); check("R4", 32'(irq_out), 0);
    wr(A_TRIG, 32'd2); cyc(1); check("R4", 32'(irq_out), 1);
    wr(A_TRIG, 0); wr(A_MASK, 0);

    // R3 routing: group 2, selector 9 -> port C bit 10
    cur_tag = "R3";
    wr(A_SEL, 32'd9 << 8); wr(A_TRIG, 32'd1 << 6); wr(A_MASK, 32'h4);
    pa_in[10] = 1'b1; cyc(3); rd_chk(A_STAT, 0, "R3");
    pc_in[10] = 1'b1; cyc(3); rd_chk(A_STAT, 32'h4, "R3");
    pc_in[10] = 1'b0; pa_in[10] = 1'b0; cyc(3); rd_chk(A_STAT, 0, "R3");
    // selector 10 -> missing port C lane, reads as 0
    wr(A_SEL, 32'd10 << 8); wr(A_TRIG, 32'd2 << 6);
    pc_in = 16'hFFFF; cyc(3); rd_chk(A_STAT, 32'h4, "R3");
    pc_in = '0; wr(A_TRIG, 0); wr(A_SEL, 0); cyc(2);

    // R5 forced pending on group 1
    cur_tag = "R5";
    wr(A_MASK, 32'h2); wr(A_TRIG, 32'd3 << 3); cyc(1);
    rd_chk(A_STAT, 32'h2, "R5");
    wr(A_ACK, 32'h2); rd_chk(A_STAT, 32'h2, "R5");
    wr(A_TRIG, 0); wr(A_MASK, 0);

    // R6 edges on group 5, selector 15 -> port D bit 29
    cur_tag = "R6";
    wr(A_SEL, 32'd15 << 20); wr(A_MASK, 32'h20); wr(A_TRIG, 32'd5 << 15);
    pd_in[29] = 1'b1; cyc(4); pd_in[29] = 1'b0; cyc(4);
    rd_chk(A_STAT, 32'h20, "R6");
    wr(A_ACK, 32'h20); rd_chk(A_STAT, 0, "R7");
    wr(A_TRIG, 32'd6 << 15);
    pd_in[29] = 1'b1; cyc(4); rd_chk(A_STAT, 0, "R6");
    pd_in[29] = 1'b0; cyc(4); rd_chk(A_STAT, 32'h20, "R6");
    wr(A_ACK, 32'h20);
    wr(A_TRIG, 32'd7 << 15);
    pd_in[29] = 1'b1; cyc(4); rd_chk(A_STAT, 32'h20, "R6");
    wr(A_ACK, 32'h20); rd_chk(A_STAT, 0, "R7");
    pd_in[29] = 1'b0; cyc(4); rd_chk(A_STAT, 32'h20, "R6");
    wr(A_ACK, 32'h20);

    // R7 edge and acknowledge on the same clock edge: edge wins
    cur_tag = "R7";
    wr(A_TRIG, 32'd5 << 15);
    pd_in[29] = 1'b1; cyc(2); wr(A_ACK, 32'h20);
    rd_chk(A_STAT, 32'h20, "R7");
    wr(A_ACK, 32'h20); rd_chk(A_STAT, 0, "R7");
    pd_in[29] = 1'b0; cyc(3);

    // R8 code 4 and code 0
    cur_tag = "R8";
    wr(A_TRIG, 32'd4 << 15);
    pd_in[29] = 1'b1; cyc(4); pd_in[29] = 1'b0; cyc(4);
    rd_chk(A_STAT, 0, "R8");
    wr(A_TRIG, 32'd7 << 15);
    pd_in[29] = 1'b1; cyc(4); rd_chk(A_STAT, 32'h20, "R8");
    wr(A_TRIG, 0); cyc(1); rd_chk(A_STAT, 0, "R8");
    pd_in[29] = 1'b0; cyc(3);

    // R9 / R10 masking
    cur_tag = "R9";
    wr(A_SEL, 0); wr(A_TRIG, 32'd3 | (32'd3 << 3)); wr(A_MASK, 32'h1); cyc(1);
    rd_chk(A_STAT, 32'h1, "R9");
    check("R10", 32'(irq_out), 1);
    wr(A_MASK, 0); check("R10", 32'(irq_out), 0);
    wr(A_MASK, 32'hFF); rd_chk(A_STAT, 32'h3, "R9");
    wr(A_TRIG, 0); wr(A_MASK, 0);

    // mixed traffic compared against the model every cycle
    cur_tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      int op;
      pa_in = pa_in ^ (($urandom % 4 == 0) ? $urandom : 32'h0);
      pb_in = pb_in ^ (($urandom % 4 == 0) ? $urandom : 32'h0);
      pc_in = pc_in ^ (($urandom % 4 == 0) ? 16'($urandom) : 16'h0);
      pd_in = pd_in ^ (($urandom % 4 == 0) ? $urandom : 32'h0);
      op = int'($urandom % 12);
      reg_wr = 1'b0; reg_rd = 1'b0;
      case (op)
        0: begin reg_wr = 1'b1; reg_addr = A_TRIG; reg_wdata = $urandom; end
        1: begin reg_wr = 1'b1; reg_addr = A_SEL;  reg_wdata = $urandom; end
        2: begin reg_wr = 1'b1; reg_addr = A_MASK; reg_wdata = $urandom; end
        3, 4: begin reg_wr = 1'b1; reg_addr = A_ACK; reg_wdata = $urandom; end
        5, 6, 7: begin reg_rd = 1'b1; reg_addr = A_STAT; end
        8: begin reg_rd = 1'b1; reg_addr = 8'($urandom % 36) * 8'd4; end
        default: ;
      endcase
      cyc(1);
    end
    reg_wr = 1'b0; reg_rd = 1'b0;
    cyc(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule